// File: doc/BRIEF.md
# Lookahead Adder/Subtractor

This block adds or subtracts two unsigned binary words in a single combinational pass. A one-bit mode input chooses the operation. When it is low the block forms the sum of the two operands. When it is high it forms the difference, using two's complement: every bit of the second operand is inverted through an exclusive-OR driven by the mode bit, and the mode bit itself becomes the carry into bit 0. The result wraps modulo two to the width. A carry-out and a signed overflow flag come with it.

The carries do not ripple from one bit to the next. Each bit first forms a generate term (both inputs set) and a propagate term (either input set). Every carry is then built directly as one AND-OR expression over those terms and the carry-in, so that each carry has the same two-level depth whatever its bit position. The word width is a parameter, so the lookahead grows with it. With the mode low and the second operand tied to 3, the block turns a decimal digit into its excess-3 code.

Top module: `lookahead_addsub`

## Requirements
- R1: With sub_mode = 0, result equals (opa + opb) mod 2^WIDTH and carry_out equals bit WIDTH of that sum.
- R2: With sub_mode = 1, result equals (opa - opb) mod 2^WIDTH, formed as opa + ~opb + 1, with the carry into bit 0 equal to sub_mode.
- R3: With sub_mode = 1, carry_out is 1 exactly when opa >= opb as unsigned values.
- R4: overflow is 1 exactly when the two's complement result of the selected operation lies outside the signed range of WIDTH bits.
- R5: Every internal carry satisfies C(i+1) = Gi OR (Pi AND Ci), where Gi = Xi AND Yi' and Pi = Xi OR Yi', with Yi' the mode-adjusted bit of opb.
- R6: Every result bit equals Xi XOR Yi' XOR Ci.
- R7: With sub_mode = 0 and opb = 4'b0011, each decimal digit 0 to 9 on opa yields its excess-3 code (digit + 3) on result, with carry_out = 0.
- R8: With both operands zero, add mode gives result 0, carry_out 0, overflow 0; subtract mode gives result 0, carry_out 1, overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand (minuend in subtract mode) |
| opb | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Signed overflow of the selected operation |

## Verification
The carry-out and the signed overflow flag can both be raised by the same operand pair, and in subtract mode the carry-out also carries the unsigned ordering of the operands. Every pair of operands is applied in both modes, which provokes all combinations: subtractions such as -8 minus 1 that set overflow while carry-out reports opa >= opb, and additions such as 8 plus 8 that set both. Each flag is judged on its own against a model that works from signed and unsigned integer arithmetic instead of bit terms, so a design that couples the two flags wrongly is caught on the pair where they differ.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } op_mode_e;

  // One bit of the sum: three-input exclusive-OR.
  function automatic logic sum_bit(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // Generate term of one bit position.
  function automatic logic gen_bit(input logic x, input logic y);
    return x & y;
  endfunction

  // Propagate term of one bit position.
  function automatic logic prop_bit(input logic x, input logic y);
    return x | y;
  endfunction

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic             mode,
  output logic [WIDTH-1:0] y_eff,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_eff[i] = y_in[i] ^ mode;
    assign gen[i]   = gen_bit(x_in[i], y_eff[i]);
    assign prop[i]  = prop_bit(x_in[i], y_eff[i]);
  end

endmodule

// File: rtl/addsub_carry_tree.sv
module addsub_carry_tree #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] prop,
  input  logic             cin,
  output logic [WIDTH:0]   carry
);

  assign carry[0] = cin;

  // Each carry is one flat OR of products: no carry feeds another.
  for (genvar i = 0; i < WIDTH; i++) begin : g_carry
    logic [i+1:0] terms;

    for (genvar j = 0; j <= i; j++) begin : g_term
      if (j == i) begin : g_top
        assign terms[j] = gen[j];
      end else begin : g_chain
        assign terms[j] = gen[j] & (&prop[i:j+1]);
      end
    end

    assign terms[i+1] = cin & (&prop[i:0]);
    assign carry[i+1] = |terms;
  end

endmodule

// File: rtl/addsub_sum.sv
module addsub_sum
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_eff,
  input  logic [WIDTH:0]   carry,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum[i] = sum_bit(x_in[i], y_eff[i], carry[i]);
  end

  assign cout = carry[WIDTH];
  assign ovf  = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);

  op_mode_e         mode;
  logic [WIDTH-1:0] y_eff;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH:0]   carry;

  assign mode = op_mode_e'(sub_mode);

  addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .x_in  (opa),
    .y_in  (opb),
    .mode  (mode == MODE_SUB),
    .y_eff (y_eff),
    .gen   (gen),
    .prop  (prop)
  );

  addsub_carry_tree #(.WIDTH(WIDTH)) u_carry (
    .gen   (gen),
    .prop  (prop),
    .cin   (mode == MODE_SUB),
    .carry (carry)
  );

  addsub_sum #(.WIDTH(WIDTH)) u_sum (
    .x_in  (opa),
    .y_eff (y_eff),
    .carry (carry),
    .sum   (result),
    .cout  (carry_out),
    .ovf   (overflow)
  );

endmodule

// File: rtl/lookahead_addsub_chk.sv
module lookahead_addsub_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             sub_mode,
  input logic [WIDTH-1:0] y_eff,
  input logic [WIDTH-1:0] gen,
  input logic [WIDTH-1:0] prop,
  input logic [WIDTH:0]   carry,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             overflow
);

  logic known;
  assign known = !$isunknown({opa, opb, sub_mode, y_eff, gen, prop, carry,
                              result, carry_out, overflow});

  always_comb begin
    if (known) begin
      // R2
      carry_in_mode_chk: assert (carry[0] == sub_mode);
      // R3
      unsigned_order_chk: assert (!sub_mode || (carry_out == (opa >= opb)));
      // R4
      no_overflow_chk: assert (overflow ==
        ((opa[WIDTH-1] == y_eff[WIDTH-1]) && (result[WIDTH-1] != opa[WIDTH-1])));
      for (int i = 0; i < WIDTH; i++) begin
        // R5
        carry_recur_chk: assert (carry[i+1] == (gen[i] | (prop[i] & carry[i])));
        // R6
        sum_bit_chk: assert (result[i] == (opa[i] ^ opb[i] ^ sub_mode ^ carry[i]));
      end
    end
  end

endmodule

bind lookahead_addsub lookahead_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .sub_mode  (sub_mode),
  .y_eff     (y_eff),
  .gen       (gen),
  .prop      (prop),
  .carry     (carry),
  .result    (result),
  .carry_out (carry_out),
  .overflow  (overflow)
);

// File: tb/lookahead_addsub_test.sv
module lookahead_addsub_test;

  localparam int W   = 4;
  localparam int MOD = 1 << W;
  localparam int HALF = MOD / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Queue of pending expectations: {result, carry_out, overflow}
  int exp_q[$];

  always #10 clk = ~clk;

  lookahead_addsub #(.WIDTH(W)) uut (
    .opa       (opa),
    .opb       (opb),
    .sub_mode  (sub_mode),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s a=%0d b=%0d m=%0d actual=%0d expected=%0d",
               req, what, opa, opb, sub_mode, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= HALF) ? v - MOD : v;
  endfunction

  // Behavioural reference: integer arithmetic only.
  task automatic apply(input int a, input int b, input int m);
    int raw, res, co, sres, ov;
    @(posedge clk);
    opa = W'(a);
    opb = W'(b);
    sub_mode = m[0];
    if (m == 0) begin
      raw  = a + b;
      res  = raw % MOD;
      co   = raw / MOD;
      sres = to_signed(a) + to_signed(b);
    end else begin
      raw  = a - b;
      res  = (raw + MOD) % MOD;
      co   = (a >= b) ? 1 : 0;
      sres = to_signed(a) - to_signed(b);
    end
    ov = (sres >= HALF || sres < -HALF) ? 1 : 0;
    exp_q.push_back((res << 2) | (co << 1) | ov);
  endtask

  // Compare at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      int e;
      string rq;
      e = exp_q.pop_front();
      rq = sub_mode ? "R2" : "R1";
      check(rq, "result", int'(result), e >> 2);
      if (sub_mode) check("R3", "carry_out", int'(carry_out), (e >> 1) & 1);
      else          check("R1", "carry_out", int'(carry_out), (e >> 1) & 1);
      check("R4", "overflow", int'(overflow), e & 1);
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // R8: zero operands right after start
    @(negedge clk);
    check("R8", "zero add result", int'(result), 0);
    check("R8", "zero add carry", int'(carry_out), 0);
    check("R8", "zero add overflow", int'(overflow), 0);
    sub_mode = 1'b1;
    @(negedge clk);
    check("R8", "zero sub result", int'(result), 0);
    check("R8", "zero sub carry", int'(carry_out), 1);
    check("R8", "zero sub overflow", int'(overflow), 0);
    rst = 1'b0;

    // R7: decimal digit to excess-3
    for (int d = 0; d < 10; d++) begin
      @(posedge clk);
      opa = W'(d);
      opb = 4'b0011;
      sub_mode = 1'b0;
      @(negedge clk);
      check("R7", "excess-3 code", int'(result), d + 3);
      check("R7", "excess-3 carry", int'(carry_out), 0);
    end

    // R1 R2 R3 R4 R5 R6: every operand pair in both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < MOD; a++)
        for (int b = 0; b < MOD; b++)
          apply(a, b, m);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
    end
  end

  initial begin
    wait (done || $time >= 20 * 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule